// File: doc/BRIEF.md
# Multi-Channel Memory-to-Memory DMA Engine

This block is a register-programmed DMA controller with a parameterised number of channels (two by default). Software fills each channel's register window with a source address, a destination address, a unit count and a command word, then sets the channel's run bit. The channel then copies data over a 32-bit valid/ready memory bus. It reads at the source port width, repacks the bytes, writes at the destination port width and counts down one unit each time a whole unit has been written.

The channel stops in one of three ways. It can finish, which sets its completed flag and, if the command asks for it, its bit in a shared interrupt-pending bitmap. It can refuse a bad setup, which sets its address-error flag and the global one. It can be stopped by software clearing the run bit or the controller enable, which sets its halted flag and the global one. Only one channel owns the memory bus at a time, and an owner keeps the bus until it stops.

Top module: `dmac_top`

## Requirements
- R1: After reset every register reads zero, no memory request is made and the interrupt outputs are low.
- R2: Bit 0 of the global word at byte offset 0x1000 stores the controller enable and reads it back. While it is clear, no channel leaves idle. A channel waiting with its run bit set starts once the enable is set.
- R3: The window of channel n is at byte offset 0x20*n, with words at source 0x00, destination 0x04, count 0x08 (24 bits), request tag 0x0C (6 bits), status 0x10 and command 0x14. Status bits are run (0), halted (2), completed (3), address error (4) and a stored mode bit (31). For each status flag, writing 0 clears it and writing 1 leaves it unchanged. Accesses whose address bits 1:0 are not zero are ignored.
- R4: A channel starts when its run bit is set, the controller is enabled and none of its three status flags is set. A valid setup with count zero sets completed at once and makes no bus access.
- R5: Port width codes (command bits 15:14 for the source, 13:12 for the destination) are 0 for 4 bytes, 1 for 1 byte and 2 for 2 bytes. Reads use the source width and writes use the destination width. Bytes keep their stream order, lowest address first, in the low data lanes. The bus size code is 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes.
- R6: Command bit 23 (source) and bit 22 (destination) make that address advance by its port width after each beat. When the bit is clear, the address stays fixed. The address words read back their current values.
- R7: Unit size codes in command bits 11:8 are 0 for 4 bytes, 1 for 1, 2 for 2, 3 for 16, 4 for 32, 5 for 64 and 6 for 128. The count drops by one for each unit written, and the completed flag is set when it reaches zero.
- R8: If command bit 1 is set, completion sets the channel's bit in the pending word at offset 0x1004, which drives the irq output. Writing 0 to a pending bit clears it.
- R9: If the source or destination address is not aligned to its port width at start, the channel sets its address-error flag and global bit 2. It makes no bus access, does not set completed and leaves the count unchanged.
- R10: Unit codes 7 and above, port width code 3, and a unit smaller than either port width are treated the same way as R9.
- R11: Clearing the run bit or the controller enable while a channel is moving data stops it after the current beat. This sets its halted flag and global bit 3 and leaves the remaining count readable.
- R12: A memory request holds its valid, address and direction until ready is seen, and only one request is outstanding.
- R13: At most one channel is granted the bus. A running channel keeps the bus until it stops. Among new requests, the lowest channel index wins.
- R14: Writes to the address, count, tag and command words of a running channel are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 13 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Memory byte address |
| mem_size | output | 2 | Beat size code |
| mem_wdata | output | 32 | Write data, low lanes used |
| mem_ready | input | 1 | Memory accepts or answers the request |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| irq | output | NCH | Per-channel interrupt pending bits |

## Verification
The assertions check, on every cycle, that a pending memory request stays stable until it is accepted, that at most one channel holds the grant, and that the count never rises while a channel runs. They also check that completed and address error are never set together, that a pending bit only rises after a completion, that a disabled controller starts nothing, and that a rising halted flag leaves the channel idle. The bench scenarios show everything that depends on data. This covers the exact read and write address sequences for mixed port widths and fixed addresses, and the byte repacking. It also covers the refused setups, the halt at a beat boundary with a partial count, the order in which two channels take the bus, and the ignored writes to a running channel.

// File: rtl/dmac_pkg.sv
// Shared types and decode helpers for the DMA engine.
// Assumes ports of 1, 2 or 4 bytes; a zero return marks an illegal code.
package dmac_pkg;

    typedef enum logic [1:0] {CH_IDLE, CH_RD, CH_WR} ch_state_t;

    localparam logic [2:0] W_SRC  = 3'd0;
    localparam logic [2:0] W_DST  = 3'd1;
    localparam logic [2:0] W_CNT  = 3'd2;
    localparam logic [2:0] W_TAG  = 3'd3;
    localparam logic [2:0] W_STAT = 3'd4;
    localparam logic [2:0] W_CMD  = 3'd5;

    // Port width code to bytes (0 means illegal).
    function automatic logic [2:0] port_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd4;
            2'd1:    return 3'd1;
            2'd2:    return 3'd2;
            default: return 3'd0;
        endcase
    endfunction

    // Unit size code to bytes (0 means illegal).
    function automatic logic [7:0] unit_bytes(input logic [3:0] code);
        case (code)
            4'd0:    return 8'd4;
            4'd1:    return 8'd1;
            4'd2:    return 8'd2;
            4'd3:    return 8'd16;
            4'd4:    return 8'd32;
            4'd5:    return 8'd64;
            4'd6:    return 8'd128;
            default: return 8'd0;
        endcase
    endfunction

    // Byte count to bus size code.
    function automatic logic [1:0] size_code(input logic [2:0] nbytes);
        case (nbytes)
            3'd1:    return 2'd0;
            3'd2:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/dmac_arb.sv
// Bus arbiter: grants at most one requester, keeps the grant with the
// current owner while it still requests, otherwise lowest index wins.
module dmac_arb #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] owner_q, pick;
    logic          owner_v_q;

    // Grant selection: locked owner first, else lowest requesting index.
    always_comb begin
        gnt  = '0;
        pick = '0;
        if (owner_v_q && req[owner_q]) begin
            pick = owner_q;
        end else begin
            for (int i = N - 1; i >= 0; i--) begin
                if (req[i]) pick = IW'(i);
            end
        end
        if (|req) gnt[pick] = 1'b1;
    end

    // Remember who holds the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q   <= '0;
            owner_v_q <= 1'b0;
        end else begin
            owner_q   <= pick;
            owner_v_q <= |req;
        end
    end

    // R13
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R13
    grant_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) && req[pick] |=> req[$past(pick)] -> gnt[$past(pick)]);

endmodule

// File: rtl/dmac_chan.sv
// One DMA channel: register window, start checks, read/repack/write engine.
// Assumes the arbiter keeps its grant while req is high; outputs are zero
// when not granted so the top can OR channels together.
module dmac_chan
    import dmac_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        glob_en,
    input  logic        wr_en,
    input  logic [2:0]  wr_word,
    input  logic [31:0] wr_data,
    input  logic [2:0]  rd_word,
    output logic [31:0] rd_data,
    output logic        req,
    input  logic        gnt,
    input  logic        bus_ready,
    input  logic [31:0] bus_rdata,
    output logic        bus_valid,
    output logic        bus_write,
    output logic [31:0] bus_addr,
    output logic [1:0]  bus_size,
    output logic [31:0] bus_wdata,
    output logic        ev_done,
    output logic        ev_err,
    output logic        ev_halt,
    output logic        irq_en
);
    ch_state_t        state_q;
    logic [31:0]      src_q, dst_q, data_q;
    logic [CNT_W-1:0] cnt_q;
    logic [5:0]       tag_q;
    logic [23:0]      cmd_q;
    logic             run_q, halt_q, done_q, aerr_q, mode_q;
    logic [2:0]       fill_q;
    logic [7:0]       left_q;

    logic [2:0]  sw, dw;
    logic [7:0]  ub;
    logic        busy, hs, stop, start, bad, unit_end;
    logic [31:0] rmask, merged;
    logic [3:0]  fill_add;
    logic [2:0]  fill_sub;

    // Decode of the command word and engine conditions.
    always_comb begin
        sw       = port_bytes(cmd_q[15:14]);
        dw       = port_bytes(cmd_q[13:12]);
        ub       = unit_bytes(cmd_q[11:8]);
        irq_en   = cmd_q[1];
        busy     = (state_q != CH_IDLE);
        stop     = !run_q || !glob_en;
        hs       = busy && gnt && bus_ready;
        start    = !busy && run_q && glob_en && !halt_q && !done_q && !aerr_q;
        bad      = (sw == 3'd0) || (dw == 3'd0) || (ub == 8'd0)
                 || (ub < {5'd0, sw}) || (ub < {5'd0, dw})
                 || (|(src_q[1:0] & (sw[1:0] - 2'd1)))
                 || (|(dst_q[1:0] & (dw[1:0] - 2'd1)));
        unit_end = hs && (state_q == CH_WR) && (left_q == {5'd0, dw});
        ev_err   = start && bad;
        ev_done  = (start && !bad && (cnt_q == '0))
                 || (unit_end && (cnt_q == CNT_W'(1)));
        ev_halt  = busy && !ev_done && stop && (hs || !gnt);
        case (sw)
            3'd1:    rmask = 32'h0000_00FF;
            3'd2:    rmask = 32'h0000_FFFF;
            default: rmask = 32'hFFFF_FFFF;
        endcase
        merged   = data_q | ((bus_rdata & rmask) << {fill_q, 3'b000});
        fill_add = {1'b0, fill_q} + {1'b0, sw};
        fill_sub = fill_q - dw;
    end

    // Bus outputs, zero unless granted.
    always_comb begin
        req       = busy;
        bus_valid = busy && gnt;
        bus_write = gnt && (state_q == CH_WR);
        bus_addr  = gnt ? ((state_q == CH_WR) ? dst_q : src_q) : 32'd0;
        bus_size  = gnt ? size_code((state_q == CH_WR) ? dw : sw) : 2'd0;
        bus_wdata = gnt ? data_q : 32'd0;
    end

    // Register readback.
    always_comb begin
        case (rd_word)
            W_SRC:   rd_data = src_q;
            W_DST:   rd_data = dst_q;
            W_CNT:   rd_data = 32'(cnt_q);
            W_TAG:   rd_data = {26'd0, tag_q};
            W_STAT:  rd_data = {mode_q, 26'd0, aerr_q, done_q, halt_q, 1'b0, run_q};
            W_CMD:   rd_data = {8'd0, cmd_q};
            default: rd_data = 32'd0;
        endcase
    end

    // Register writes, flag updates and the transfer state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            src_q   <= '0;
            dst_q   <= '0;
            data_q  <= '0;
            cnt_q   <= '0;
            tag_q   <= '0;
            cmd_q   <= '0;
            run_q   <= 1'b0;
            halt_q  <= 1'b0;
            done_q  <= 1'b0;
            aerr_q  <= 1'b0;
            mode_q  <= 1'b0;
            fill_q  <= '0;
            left_q  <= '0;
        end else begin
            if (wr_en) begin
                case (wr_word)
                    W_SRC:  if (!busy) src_q <= wr_data;
                    W_DST:  if (!busy) dst_q <= wr_data;
                    W_CNT:  if (!busy) cnt_q <= wr_data[CNT_W-1:0];
                    W_TAG:  if (!busy) tag_q <= wr_data[5:0];
                    W_CMD:  if (!busy) cmd_q <= wr_data[23:0];
                    W_STAT: begin
                        run_q  <= wr_data[0];
                        halt_q <= halt_q & wr_data[2];
                        done_q <= done_q & wr_data[3];
                        aerr_q <= aerr_q & wr_data[4];
                        mode_q <= wr_data[31];
                    end
                    default: ;
                endcase
            end
            case (state_q)
                CH_IDLE: if (start && !bad && (cnt_q != '0)) begin
                    state_q <= CH_RD;
                    fill_q  <= '0;
                    data_q  <= '0;
                    left_q  <= ub;
                end
                CH_RD: if (hs) begin
                    data_q  <= merged;
                    fill_q  <= fill_add[2:0];
                    if (cmd_q[23]) src_q <= src_q + 32'(sw);
                    state_q <= (fill_add >= {1'b0, dw}) ? CH_WR : CH_RD;
                end
                CH_WR: if (hs) begin
                    data_q  <= data_q >> {dw, 3'b000};
                    fill_q  <= fill_sub;
                    if (cmd_q[22]) dst_q <= dst_q + 32'(dw);
                    if (unit_end) begin
                        cnt_q  <= cnt_q - CNT_W'(1);
                        left_q <= ub;
                    end else begin
                        left_q <= left_q - {5'd0, dw};
                    end
                    state_q <= (fill_sub >= dw) ? CH_WR : CH_RD;
                end
                default: state_q <= CH_IDLE;
            endcase
            if (ev_done || ev_halt) state_q <= CH_IDLE;
            if (ev_err)  aerr_q <= 1'b1;
            if (ev_done) done_q <= 1'b1;
            if (ev_halt) halt_q <= 1'b1;
        end
    end

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_write));

    // R7
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> cnt_q <= $past(cnt_q));

    // R9
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_q && aerr_q));

    // R11
    halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_q) |-> !busy);

endmodule

// File: rtl/dmac_top.sv
// DMA controller top: global enable/flags, interrupt-pending bitmap,
// register address decode, channel array and memory bus merge.
// Assumes word-aligned register accesses; NCH is at most 32.
module dmac_top
    import dmac_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int CNT_W = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [12:0]    reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    output logic           mem_valid,
    output logic           mem_write,
    output logic [31:0]    mem_addr,
    output logic [1:0]     mem_size,
    output logic [31:0]    mem_wdata,
    input  logic           mem_ready,
    input  logic [31:0]    mem_rdata,
    output logic [NCH-1:0] irq
);
    localparam int CI_W = 7;

    logic [CI_W-1:0] ch_idx;
    logic            aligned, glob_sel, ctrl_we, pend_we;
    logic            g_en_q, g_err_q, g_halt_q;
    logic [NCH-1:0]  pend_q, req, gnt, ch_we, ev_done, ev_err, ev_halt, ch_irq_en;
    logic [NCH-1:0]  b_valid, b_write;
    logic [31:0]     ch_rd   [NCH];
    logic [31:0]     b_addr  [NCH];
    logic [31:0]     b_wdata [NCH];
    logic [1:0]      b_size  [NCH];

    // Address decode for global and channel windows.
    always_comb begin
        ch_idx   = reg_addr[11:5];
        aligned  = (reg_addr[1:0] == 2'b00);
        glob_sel = aligned && reg_addr[12];
        ctrl_we  = reg_we && glob_sel && (reg_addr[11:2] == 10'd0);
        pend_we  = reg_we && glob_sel && (reg_addr[11:2] == 10'd1);
        for (int i = 0; i < NCH; i++) begin
            ch_we[i] = reg_we && aligned && !reg_addr[12] && (ch_idx == CI_W'(i));
        end
    end

    // Read data mux.
    always_comb begin
        reg_rdata = 32'd0;
        if (aligned) begin
            if (reg_addr[12]) begin
                if (reg_addr[11:2] == 10'd0)
                    reg_rdata = {28'd0, g_halt_q, g_err_q, 1'b0, g_en_q};
                else if (reg_addr[11:2] == 10'd1)
                    reg_rdata = 32'(pend_q);
            end else begin
                for (int i = 0; i < NCH; i++) begin
                    if (ch_idx == CI_W'(i)) reg_rdata = ch_rd[i];
                end
            end
        end
    end

    // Global control flags and interrupt-pending bitmap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_en_q   <= 1'b0;
            g_err_q  <= 1'b0;
            g_halt_q <= 1'b0;
            pend_q   <= '0;
        end else begin
            if (ctrl_we) begin
                g_en_q   <= reg_wdata[0];
                g_err_q  <= g_err_q & reg_wdata[2];
                g_halt_q <= g_halt_q & reg_wdata[3];
            end
            if (|ev_err)  g_err_q  <= 1'b1;
            if (|ev_halt) g_halt_q <= 1'b1;
            pend_q <= (pend_we ? (pend_q & reg_wdata[NCH-1:0]) : pend_q)
                    | (ev_done & ch_irq_en);
        end
    end

    assign irq = pend_q;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dmac_chan #(.CNT_W(CNT_W)) i_chan (
            .clk(clk), .rst_n(rst_n), .glob_en(g_en_q),
            .wr_en(ch_we[g]), .wr_word(reg_addr[4:2]), .wr_data(reg_wdata),
            .rd_word(reg_addr[4:2]), .rd_data(ch_rd[g]),
            .req(req[g]), .gnt(gnt[g]), .bus_ready(mem_ready), .bus_rdata(mem_rdata),
            .bus_valid(b_valid[g]), .bus_write(b_write[g]), .bus_addr(b_addr[g]),
            .bus_size(b_size[g]), .bus_wdata(b_wdata[g]),
            .ev_done(ev_done[g]), .ev_err(ev_err[g]), .ev_halt(ev_halt[g]),
            .irq_en(ch_irq_en[g])
        );

        // R8
        pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_q[g]) |-> $past(ev_done[g]));
    end

    dmac_arb #(.N(NCH)) i_arb (.clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt));

    // Merge of the granted channel onto the memory bus.
    always_comb begin
        mem_valid = |b_valid;
        mem_write = |b_write;
        mem_addr  = '0;
        mem_size  = '0;
        mem_wdata = '0;
        for (int i = 0; i < NCH; i++) begin
            mem_addr  = mem_addr  | b_addr[i];
            mem_size  = mem_size  | b_size[i];
            mem_wdata = mem_wdata | b_wdata[i];
        end
    end

    // R2
    no_start_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !g_en_q && !(|req) |=> !(|req));

endmodule

// File: tb/test_dmac_top.sv
`timescale 1ns/1ps
module test_dmac_top;
    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_we = 1'b0;
    logic [12:0]    reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic           mem_valid, mem_write, mem_ready;
    logic [31:0]    mem_addr, mem_wdata, mem_rdata;
    logic [1:0]     mem_size;
    logic [NCH-1:0] irq;

    int n_chk = 0;
    int n_bad = 0;
    int beats = 0;
    int rcnt  = 0;

    logic [7:0]  mem [0:4095];
    int          q_ra[$];
    int          q_rs[$];
    int          q_wa[$];
    int          q_ws[$];
    logic [31:0] q_wd[$];

    always #10 clk = ~clk;

    dmac_top #(.NCH(NCH)) i_dmac_top (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_valid(mem_valid),
        .mem_write(mem_write), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata), .irq(irq));

    assign mem_rdata = {mem[mem_addr[11:0] + 12'd3], mem[mem_addr[11:0] + 12'd2],
                        mem[mem_addr[11:0] + 12'd1], mem[mem_addr[11:0]]};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int pbytes(input int c);
        return (c == 1) ? 1 : (c == 2) ? 2 : 4;
    endfunction

    function automatic int ubytes(input int c);
        case (c)
            1: return 1;  2: return 2;  3: return 16;  4: return 32;
            5: return 64; 6: return 128; default: return 4;
        endcase
    endfunction

    function automatic logic [31:0] mk_cmd(input int si, input int di, input int swc,
                                           input int dwc, input int uc, input int ie);
        return 32'((si << 23) | (di << 22) | (swc << 14) | (dwc << 12) | (uc << 8) | (ie << 1));
    endfunction

    // Memory ready pattern: a stall every third cycle.
    always @(posedge clk) begin
        rcnt      <= rcnt + 1;
        mem_ready <= rst_n && ((rcnt % 3) != 2);
    end

    // Per-cycle comparison of bus traffic against the reference queues (R5, R6, R12).
    always @(negedge clk) begin
        if (rst_n && mem_valid && mem_ready) begin
            beats++;
            if (!mem_write) begin
                if (q_ra.size() == 0) check("R12 unexpected read", mem_addr, 32'hFFFF_FFFF);
                else begin
                    check("R6 read address", mem_addr, 32'(q_ra.pop_front()));
                    check("R5 read size", 32'(mem_size), 32'(q_rs.pop_front()));
                end
            end else begin
                if (q_wa.size() == 0) check("R12 unexpected write", mem_addr, 32'hFFFF_FFFF);
                else begin
                    int sz;
                    logic [31:0] m;
                    sz = q_ws.pop_front();
                    m  = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
                    check("R6 write address", mem_addr, 32'(q_wa.pop_front()));
                    check("R5 write size", 32'(mem_size), 32'(sz));
                    check("R5 write data", mem_wdata & m, q_wd.pop_front());
                end
                for (int b = 0; b < 4; b++) begin
                    if (b < ((mem_size == 2'd0) ? 1 : (mem_size == 2'd1) ? 2 : 4))
                        mem[mem_addr[11:0] + 12'(b)] = mem_wdata[b*8 +: 8];
                end
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 13'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 13'(a);
        #1 d = reg_rdata;
    endtask

    // Reference model: expected read and write beats of one transfer.
    task automatic gen(input int src, input int dst, input int cnt, input int si, input int di,
                       input int swc, input int dwc, input int uc);
        int sw, dw, tot;
        logic [7:0] bs[$];
        sw = pbytes(swc); dw = pbytes(dwc); tot = cnt * ubytes(uc);
        for (int j = 0; j < tot / sw; j++) begin
            int a;
            a = si ? src + j * sw : src;
            q_ra.push_back(a);
            q_rs.push_back(sw == 1 ? 0 : sw == 2 ? 1 : 2);
            for (int b = 0; b < sw; b++) bs.push_back(mem[12'(a + b)]);
        end
        for (int m = 0; m < tot / dw; m++) begin
            logic [31:0] d;
            d = '0;
            for (int b = 0; b < dw; b++) d[b*8 +: 8] = bs[m * dw + b];
            q_wa.push_back(di ? dst + m * dw : dst);
            q_ws.push_back(dw == 1 ? 0 : dw == 2 ? 1 : 2);
            q_wd.push_back(d);
        end
    endtask

    task automatic setup(input int ch, input int src, input int dst, input int cnt,
                         input logic [31:0] cmd);
        wr(ch * 32 + 'h00, 32'(src));
        wr(ch * 32 + 'h04, 32'(dst));
        wr(ch * 32 + 'h08, 32'(cnt));
        wr(ch * 32 + 'h14, cmd);
    endtask

    task automatic wait_end(input int ch, output logic [31:0] st);
        int n;
        n = 0;
        do begin
            rd(ch * 32 + 'h10, st);
            n++;
        end while ((st & 32'h1C) == 0 && n < 3000);
        if (n >= 3000) check("R4 channel never stopped", st, 32'h8);
    endtask

    task automatic queues_empty(input string tag);
        check(tag, 32'(q_ra.size() + q_wa.size()), 32'd0);
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int b0;
        for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 13 + 7);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd('h1000, v); check("R1 global word", v, 0);
        rd('h1004, v); check("R1 pending word", v, 0);
        rd('h10, v);   check("R1 status ch0", v, 0);
        rd('h28, v);   check("R1 count ch1", v, 0);
        check("R1 mem_valid", 32'(mem_valid), 0);
        check("R1 irq", 32'(irq), 0);

        // R3: request tag width and unaligned access ignored
        wr('h2C, 32'hFF); rd('h2C, v); check("R3 tag width", v, 32'h3F);
        wr('h2D, 32'h0);  rd('h2C, v); check("R3 unaligned write ignored", v, 32'h3F);

        // R2: enable readback
        wr('h1000, 1); rd('h1000, v); check("R2 enable readback", v, 1);

        // R5 R6 R7 R8: plain word copy
        setup(0, 'h100, 'h200, 3, mk_cmd(1, 1, 0, 0, 0, 1));
        gen('h100, 'h200, 3, 1, 1, 0, 0, 0);
        wr('h10, 32'h8000_0001);
        wait_end(0, v);
        check("R7 completed ch0", v, 32'h8000_0009);
        rd('h08, v); check("R7 count zero", v, 0);
        rd('h00, v); check("R6 source advanced", v, 32'h10C);
        rd('h04, v); check("R6 destination advanced", v, 32'h20C);
        rd('h1004, v); check("R8 pending set", v, 1);
        check("R8 irq output", 32'(irq), 1);
        queues_empty("R5 all beats seen");
        wr('h1004, 0); rd('h1004, v); check("R8 pending cleared", v, 0);
        wr('h10, 0);   rd('h10, v);   check("R3 flags cleared by zero", v, 0);

        // R5 R7: byte reads, word writes, 16-byte units
        setup(1, 'h300, 'h400, 2, mk_cmd(1, 1, 1, 0, 3, 0));
        gen('h300, 'h400, 2, 1, 1, 1, 0, 3);
        wr('h30, 1);
        wait_end(1, v);
        check("R7 completed mixed widths", v, 32'h9);
        queues_empty("R5 mixed widths beats");
        rd('h1004, v); check("R8 no pending without enable bit", v, 0);
        wr('h30, 0);

        // R6: word reads, halfword writes, fixed destination
        setup(0, 'h500, 'h600, 2, mk_cmd(1, 0, 0, 2, 0, 0));
        gen('h500, 'h600, 2, 1, 0, 0, 2, 0);
        wr('h10, 1);
        wait_end(0, v);
        check("R6 fixed destination done", v, 32'h9);
        rd('h04, v); check("R6 destination unchanged", v, 32'h600);
        queues_empty("R6 fixed destination beats");
        wr('h10, 0);

        // R6: fixed source halfwords
        setup(0, 'h700, 'h780, 3, mk_cmd(0, 1, 2, 2, 2, 0));
        gen('h700, 'h780, 3, 0, 1, 2, 2, 2);
        wr('h10, 1);
        wait_end(0, v);
        rd('h00, v); check("R6 source unchanged", v, 32'h700);
        queues_empty("R6 fixed source beats");
        wr('h10, 0);

        // R4: zero count completes with no traffic
        b0 = beats;
        setup(0, 'h100, 'h200, 0, mk_cmd(1, 1, 0, 0, 0, 1));
        wr('h10, 1);
        wait_end(0, v);
        check("R4 zero count completes", v, 32'h9);
        check("R4 zero count no beats", 32'(beats - b0), 0);
        wr('h1004, 0); wr('h10, 0);

        // R9: misaligned source
        b0 = beats;
        setup(0, 'h102, 'h200, 5, mk_cmd(1, 1, 0, 0, 0, 1));
        wr('h10, 1);
        wait_end(0, v);
        check("R9 address error not completed", v & 32'h1C, 32'h10);
        rd('h1000, v); check("R9 global error", v, 32'h5);
        rd('h08, v);   check("R9 count kept", v, 5);
        check("R9 no beats", 32'(beats - b0), 0);
        rd('h1004, v); check("R9 no pending", v, 0);
        wr('h10, 0); wr('h1000, 1);
        rd('h1000, v); check("R9 global error cleared", v, 1);

        // R10: illegal unit code, illegal port code, unit smaller than port
        setup(0, 'h100, 'h200, 1, mk_cmd(1, 1, 0, 0, 7, 0));
        wr('h10, 1); wait_end(0, v);
        check("R10 unit code 7", v & 32'h1C, 32'h10);
        wr('h10, 0);
        setup(0, 'h100, 'h200, 1, mk_cmd(1, 1, 3, 0, 0, 0));
        wr('h10, 1); wait_end(0, v);
        check("R10 port code 3", v & 32'h1C, 32'h10);
        wr('h10, 0);
        setup(0, 'h100, 'h200, 1, mk_cmd(1, 1, 0, 0, 1, 0));
        wr('h10, 1); wait_end(0, v);
        check("R10 unit below port width", v & 32'h1C, 32'h10);
        check("R10 no beats", 32'(beats - b0), 0);
        wr('h10, 0); wr('h1000, 1);

        // R2: disabled controller holds a ready channel
        wr('h1000, 0);
        setup(0, 'h800, 'h880, 2, mk_cmd(1, 1, 0, 0, 0, 0));
        gen('h800, 'h880, 2, 1, 1, 0, 0, 0);
        b0 = beats;
        wr('h10, 1);
        repeat (20) @(negedge clk);
        rd('h10, v); check("R2 no start while disabled", v, 1);
        check("R2 no beats while disabled", 32'(beats - b0), 0);
        wr('h1000, 1);
        wait_end(0, v);
        check("R2 starts after enable", v, 32'h9);
        queues_empty("R2 beats after enable");
        wr('h10, 0);

        // R11: halt mid-transfer
        setup(0, 'h900, 'hA00, 40, mk_cmd(1, 1, 0, 0, 0, 1));
        gen('h900, 'hA00, 40, 1, 1, 0, 0, 0);
        wr('h10, 1);
        repeat (30) @(negedge clk);
        wr('h10, 0);
        wait_end(0, v);
        check("R11 halted flag", v & 32'h1C, 32'h4);
        rd('h08, v);
        check("R11 partial count", 32'((v > 0) && (v < 40)), 1);
        rd('h1000, v); check("R11 global halt", v, 32'h9);
        rd('h1004, v); check("R11 no pending on halt", v, 0);
        q_ra.delete(); q_rs.delete(); q_wa.delete(); q_ws.delete(); q_wd.delete();
        b0 = beats;
        repeat (20) @(negedge clk);
        check("R11 bus quiet after halt", 32'(beats - b0), 0);
        wr('h10, 0); wr('h1000, 1);

        // R13 R14: two channels, channel 1 first, write to running channel ignored
        setup(1, 'hB00, 'hB80, 4, mk_cmd(1, 1, 0, 0, 0, 1));
        setup(0, 'hC00, 'hC80, 2, mk_cmd(1, 1, 2, 2, 2, 1));
        gen('hB00, 'hB80, 4, 1, 1, 0, 0, 0);
        gen('hC00, 'hC80, 2, 1, 1, 2, 2, 2);
        wr('h30, 1);
        wr('h10, 1);
        wr('h20, 32'hFFC);
        wr('h28, 32'd99);
        wait_end(1, v); check("R13 channel 1 done", v, 32'h9);
        wait_end(0, v); check("R13 channel 0 done", v, 32'h9);
        queues_empty("R13 bus order");
        rd('h20, v); check("R14 source write ignored", v, 32'hB10);
        rd('h28, v); check("R14 count write ignored", v, 0);
        rd('h1004, v); check("R8 both pending", v, 3);
        wr('h1004, 1);
        rd('h1004, v); check("R8 clear one bit", v, 1);
        check("R8 irq follows pending", 32'(irq), 1);

        finish_run();
    end
endmodule